// File: doc/BRIEF.md
# Fracturable six-input logic module

This block is a configurable look-up element with eight data inputs and a 64-bit truth-table mask. The mask is held as four 16-entry quarter tables, Q0 to Q3, where mask bit `16*k + j` is entry `j` of quarter `k`. Five configuration bits choose how the quarters are addressed and merged. The block can act as two independent 4-input functions, two 5-input functions with shared low inputs, one 6-input function, two 6-input functions read from one mask with different upper selects, or a 7-input function with a limited form.

Each half of the block has its own combinational result. Each result also goes to its own flip-flop, which has a synchronous clear and a clock enable. A surrounding fabric drives the mask and configuration as static settings and drives the data inputs as live signals.

Input bit map of `lut_in`: [0]=A0 and [1]=A1 (common), [2]=PU, [3]=PL, [4]=QU, [5]=QL, [6]=SU, [7]=SL (U = upper half, L = lower half). Flat indices below are mask bit positions, written MSB first.

Top module: `frac_alm`

## Requirements
- R1: Mode decode, first match wins: TWIN6 when swap_hi=1, swap_lo=1, split=0 and spread=1; otherwise PART7 when swap_hi=0, swap_lo=1 and split=1; otherwise WIDE6 when tie=1; otherwise PAIR5 when spread=1; otherwise QUAD4.
- R2: QUAD4: comb_hi = mask[{SU,QU,PU,A0}] and comb_lo = mask[32+{SL,QL,PL,A1}].
- R3: PAIR5: comb_hi = mask[{SU,QU,PU,A1,A0}] and comb_lo = mask[32+{SL,QL,PL,A1,A0}].
- R4: WIDE6, with PL tied to PU and QL tied to QU: comb_hi = comb_lo = mask[{SL,SU,QU,PU,A1,A0}].
- R5: TWIN6: comb_hi = mask[{SU,QU,PL,PU,A1,A0}] and comb_lo = mask[{SL,QL,PL,PU,A1,A0}].
- R6: PART7: when QU=0 both outputs are mask[{SU,PL,PU,A1,A0}]. When QU=1 both outputs are mask[32+{SU,QL,PL,A1,A0}]. SL has no effect.
- R7: In QUAD4, comb_lo does not change when only SU, QU, PU or A0 change.
- R8: On a rising clock edge with enable=1 and clear=0, reg_hi and reg_lo take the values that comb_hi and comb_lo had before the edge.
- R9: With enable=0 and clear=0, reg_hi and reg_lo keep their values across clock edges, even when the inputs change.
- R10: A synchronous clear, or the synchronous active-high reset, drives both registered outputs to 0 on the next rising edge. Clear wins over enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both flip-flops |
| rst | input | 1 | Synchronous active-high reset of both flip-flops |
| mask | input | 64 | Truth-table contents, four 16-bit quarters |
| cfg_tie | input | 1 | Joins the halves into one 6-input function |
| cfg_swap_hi | input | 1 | Upper swap select |
| cfg_swap_lo | input | 1 | Lower swap select |
| cfg_split | input | 1 | Partial 7-input select |
| cfg_spread | input | 1 | Enables the fifth-stage select in each half |
| lut_in | input | 8 | Data inputs, bit map above |
| ff_clr | input | 1 | Synchronous clear of both flip-flops |
| ff_en | input | 1 | Clock enable of both flip-flops |
| comb_hi | output | 1 | Upper combinational result |
| comb_lo | output | 1 | Lower combinational result |
| reg_hi | output | 1 | Upper registered result |
| reg_lo | output | 1 | Lower registered result |

## Verification
The hardest case to reach is the set of configuration words where more than one mode's conditions hold at once, because the decode priority only shows there. The stimulus drives words that meet the WIDE6, TWIN6 and PART7 conditions together, then sweeps the inputs against a flat-index reference. Isolation in QUAD4 is checked by holding the lower-half inputs fixed while every upper-only input combination is swept.

// File: rtl/frac_alm_pkg.sv
package frac_alm_pkg;

    localparam int QADDR_W  = 4;
    localparam int QBITS    = 1 << QADDR_W;
    localparam int NQUARTER = 4;
    localparam int MASK_W   = NQUARTER * QBITS;
    localparam int NIN      = 8;

    typedef enum logic [2:0] {
        MODE_QUAD4 = 3'd0,
        MODE_PAIR5 = 3'd1,
        MODE_WIDE6 = 3'd2,
        MODE_TWIN6 = 3'd3,
        MODE_PART7 = 3'd4
    } alm_mode_e;

    typedef struct packed {
        logic tie;
        logic swap_hi;
        logic swap_lo;
        logic split;
        logic spread;
    } alm_cfg_t;

    typedef struct packed {
        logic [QADDR_W-1:0] up;
        logic [QADDR_W-1:0] lo;
    } alm_addr_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } alm_pair_t;

    function automatic alm_mode_e decode_mode(alm_cfg_t c);
        if (c.swap_hi && c.swap_lo && !c.split && c.spread)
            return MODE_TWIN6;
        else if (!c.swap_hi && c.swap_lo && c.split)
            return MODE_PART7;
        else if (c.tie)
            return MODE_WIDE6;
        else if (c.spread)
            return MODE_PAIR5;
        else
            return MODE_QUAD4;
    endfunction

    function automatic logic pick2(logic sel, logic when0, logic when1);
        return sel ? when1 : when0;
    endfunction

endpackage

// File: rtl/alm_quarter.sv
module alm_quarter #(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic [DEPTH-1:0]  table_bits,
    input  logic [ADDR_W-1:0] addr,
    output logic              y
);
    assign y = table_bits[addr];
endmodule

// File: rtl/alm_addr_gen.sv
module alm_addr_gen
    import frac_alm_pkg::*;
(
    input  alm_mode_e      mode,
    input  logic [NIN-1:0] din,
    output alm_addr_t      addr
);
    always_comb begin
        unique case (mode)
            MODE_QUAD4: begin
                addr.up = {din[6], din[4], din[2], din[0]};
                addr.lo = {din[7], din[5], din[3], din[1]};
            end
            MODE_PAIR5, MODE_WIDE6: begin
                addr.up = {din[4], din[2], din[1], din[0]};
                addr.lo = {din[5], din[3], din[1], din[0]};
            end
            MODE_PART7: begin
                addr.up = {din[3], din[2], din[1], din[0]};
                addr.lo = {din[5], din[3], din[1], din[0]};
            end
            default: begin
                addr.up = {din[3], din[2], din[1], din[0]};
                addr.lo = {din[3], din[2], din[1], din[0]};
            end
        endcase
    end
endmodule

// File: rtl/alm_out_mux.sv
module alm_out_mux
    import frac_alm_pkg::*;
(
    input  alm_mode_e             mode,
    input  logic [NQUARTER-1:0]   q,
    input  logic [3:0]            sel,   // {SL, SU, QL, QU}
    output alm_pair_t             y
);
    logic su, sl, qu, ql;
    logic upper5, lower5;

    assign qu = sel[0];
    assign ql = sel[1];
    assign su = sel[2];
    assign sl = sel[3];

    always_comb begin
        upper5 = pick2(su, q[0], q[1]);
        lower5 = pick2(su, q[2], q[3]);
        unique case (mode)
            MODE_QUAD4: begin
                y.hi = q[0];
                y.lo = q[2];
            end
            MODE_PAIR5: begin
                y.hi = upper5;
                y.lo = pick2(sl, q[2], q[3]);
            end
            MODE_WIDE6: begin
                y.hi = pick2(sl, upper5, lower5);
                y.lo = y.hi;
            end
            MODE_TWIN6: begin
                y.hi = q[{su, qu}];
                y.lo = q[{sl, ql}];
            end
            default: begin
                y.hi = pick2(qu, upper5, lower5);
                y.lo = y.hi;
            end
        endcase
    end
endmodule

// File: rtl/alm_reg.sv
module alm_reg (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= 1'b0;
        else if (en)
            q <= d;
    end
endmodule

// File: rtl/frac_alm.sv
module frac_alm
    import frac_alm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MASK_W-1:0] mask,
    input  logic              cfg_tie,
    input  logic              cfg_swap_hi,
    input  logic              cfg_swap_lo,
    input  logic              cfg_split,
    input  logic              cfg_spread,
    input  logic [NIN-1:0]    lut_in,
    input  logic              ff_clr,
    input  logic              ff_en,
    output logic              comb_hi,
    output logic              comb_lo,
    output logic              reg_hi,
    output logic              reg_lo
);
    alm_cfg_t            cfg;
    alm_mode_e           mode;
    alm_addr_t           addr;
    logic [NQUARTER-1:0] qout;
    alm_pair_t           res;

    assign cfg  = '{tie: cfg_tie, swap_hi: cfg_swap_hi, swap_lo: cfg_swap_lo,
                    split: cfg_split, spread: cfg_spread};
    assign mode = decode_mode(cfg);

    alm_addr_gen u_addr (
        .mode (mode),
        .din  (lut_in),
        .addr (addr)
    );

    for (genvar k = 0; k < NQUARTER; k++) begin : g_quarter
        localparam bit UPPER = (k < NQUARTER / 2);
        alm_quarter #(.ADDR_W(QADDR_W)) u_q (
            .table_bits (mask[k*QBITS +: QBITS]),
            .addr       (UPPER ? addr.up : addr.lo),
            .y          (qout[k])
        );
    end

    alm_out_mux u_mux (
        .mode (mode),
        .q    (qout),
        .sel  (lut_in[7:4]),
        .y    (res)
    );

    assign comb_hi = res.hi;
    assign comb_lo = res.lo;

    alm_reg u_reg_hi (
        .clk (clk), .rst (rst), .clr (ff_clr), .en (ff_en),
        .d   (res.hi), .q (reg_hi)
    );

    alm_reg u_reg_lo (
        .clk (clk), .rst (rst), .clr (ff_clr), .en (ff_en),
        .d   (res.lo), .q (reg_lo)
    );
endmodule

// File: rtl/frac_alm_chk.sv
module frac_alm_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_tie,
    input logic       cfg_swap_hi,
    input logic       cfg_swap_lo,
    input logic       cfg_split,
    input logic       cfg_spread,
    input logic [7:0] lut_in,
    input logic       ff_clr,
    input logic       ff_en,
    input logic       comb_hi,
    input logic       comb_lo,
    input logic       reg_hi,
    input logic       reg_lo
);
    logic twin_cfg, part_cfg, wide_cfg;
    assign twin_cfg = cfg_swap_hi && cfg_swap_lo && !cfg_split && cfg_spread;
    assign part_cfg = !twin_cfg && !cfg_swap_hi && cfg_swap_lo && cfg_split;
    assign wide_cfg = !twin_cfg && !part_cfg && cfg_tie;

    // R10: clear empties both flops on the next edge
    p_clear_zero_r10: assert property (@(posedge clk) disable iff (rst)
        ff_clr |=> (!reg_hi && !reg_lo));

    // R9: flops hold with enable low
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!ff_clr && !ff_en) |=> ($stable(reg_hi) && $stable(reg_lo)));

    // R8: flops capture the combinational results
    p_capture_r8: assert property (@(posedge clk) disable iff (rst)
        (!ff_clr && ff_en) |=> (reg_hi == $past(comb_hi) && reg_lo == $past(comb_lo)));

    // R4, R6: joined modes drive both outputs alike
    p_joined_equal_r4: assert property (@(posedge clk) disable iff (rst)
        ((wide_cfg && lut_in[5] == lut_in[4] && lut_in[3] == lut_in[2]) || part_cfg)
            |-> (comb_hi == comb_lo));

    // R5: shared mask with equal upper selects gives equal outputs
    p_twin_equal_r5: assert property (@(posedge clk) disable iff (rst)
        (twin_cfg && lut_in[6] == lut_in[7] && lut_in[4] == lut_in[5])
            |-> (comb_hi == comb_lo));
endmodule

bind frac_alm frac_alm_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_tie     (cfg_tie),
    .cfg_swap_hi (cfg_swap_hi),
    .cfg_swap_lo (cfg_swap_lo),
    .cfg_split   (cfg_split),
    .cfg_spread  (cfg_spread),
    .lut_in      (lut_in),
    .ff_clr      (ff_clr),
    .ff_en       (ff_en),
    .comb_hi     (comb_hi),
    .comb_lo     (comb_lo),
    .reg_hi      (reg_hi),
    .reg_lo      (reg_lo)
);

// File: tb/frac_alm_tb.sv
module frac_alm_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] mask = '0;
    logic        cfg_tie = 0, cfg_swap_hi = 0, cfg_swap_lo = 0, cfg_split = 0, cfg_spread = 0;
    logic [7:0]  lut_in = '0;
    logic        ff_clr = 0, ff_en = 0;
    logic        comb_hi, comb_lo, reg_hi, reg_lo;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #5 clk = ~clk;

    frac_alm u_dut (
        .clk (clk), .rst (rst), .mask (mask),
        .cfg_tie (cfg_tie), .cfg_swap_hi (cfg_swap_hi), .cfg_swap_lo (cfg_swap_lo),
        .cfg_split (cfg_split), .cfg_spread (cfg_spread),
        .lut_in (lut_in), .ff_clr (ff_clr), .ff_en (ff_en),
        .comb_hi (comb_hi), .comb_lo (comb_lo), .reg_hi (reg_hi), .reg_lo (reg_lo)
    );

    // bench mode codes: 0 QUAD4, 1 PAIR5, 2 WIDE6, 3 TWIN6, 4 PART7
    function automatic int ref_mode(bit t, bit rh, bit rl, bit s, bit u);
        if (rh && rl && !s && u) return 3;
        if (!rh && rl && s) return 4;
        if (t) return 2;
        if (u) return 1;
        return 0;
    endfunction

    function automatic bit ref_out(int m, logic [63:0] mk, logic [7:0] i, bit upper);
        int idx;
        case (m)
            0: idx = upper ? int'({i[6], i[4], i[2], i[0]})
                           : 32 + int'({i[7], i[5], i[3], i[1]});
            1: idx = upper ? int'({i[6], i[4], i[2], i[1], i[0]})
                           : 32 + int'({i[7], i[5], i[3], i[1], i[0]});
            2: idx = int'({i[7], i[6], i[4], i[2], i[1], i[0]});
            3: idx = upper ? int'({i[6], i[4], i[3], i[2], i[1], i[0]})
                           : int'({i[7], i[5], i[3], i[2], i[1], i[0]});
            default: idx = i[4] ? 32 + int'({i[6], i[5], i[3], i[1], i[0]})
                                : int'({i[6], i[3], i[2], i[1], i[0]});
        endcase
        return mk[idx];
    endfunction

    task automatic check(string req, logic act, logic exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0b expected=%0b (in=%02h mask=%016h)", req, act, exp, lut_in, mask);
        end
    endtask

    task automatic set_cfg(bit t, bit rh, bit rl, bit s, bit u);
        cfg_tie = t; cfg_swap_hi = rh; cfg_swap_lo = rl; cfg_split = s; cfg_spread = u;
    endtask

    task automatic sweep(string req, bit tie_pairs);
        int m = ref_mode(cfg_tie, cfg_swap_hi, cfg_swap_lo, cfg_split, cfg_spread);
        for (int v = 0; v < 256; v++) begin
            logic [7:0] x = 8'(v);
            if (tie_pairs) begin
                x[5] = x[4];
                x[3] = x[2];
            end
            lut_in = x;
            #1;
            check(req, comb_hi, ref_out(m, mask, x, 1'b1));
            check(req, comb_lo, ref_out(m, mask, x, 1'b0));
        end
    endtask

    task automatic t_reset_state();
        // R10: reset leaves both flops at zero
        check("R10 reset hi", reg_hi, 1'b0);
        check("R10 reset lo", reg_lo, 1'b0);
    endtask

    task automatic t_quad4();
        mask = 64'hC3A5_96F0_1E7D_2B48;
        set_cfg(0, 0, 0, 0, 0);
        sweep("R2 quad4", 0);
        mask = 64'h0123_4567_89AB_CDEF;
        set_cfg(0, 1, 0, 0, 0);    // swap alone keeps QUAD4 (R1)
        sweep("R2 quad4 swap-only R1", 0);
    endtask

    task automatic t_isolation();
        // R7: sweep upper-only inputs with lower ones fixed
        mask = 64'h5A3C_F00F_9966_E1D2;
        set_cfg(0, 0, 0, 0, 0);
        for (int low = 0; low < 16; low++) begin
            logic [7:0] base = {low[3], 1'b0, low[2], 1'b0, low[1], 1'b0, low[0], 1'b0};
            logic       exp_lo;
            lut_in = base;
            #1;
            exp_lo = comb_lo;
            check("R7 quad4 baseline", exp_lo, ref_out(0, mask, base, 1'b0));
            for (int up = 1; up < 16; up++) begin
                lut_in = base | {1'b0, up[3], 1'b0, up[2], 1'b0, up[1], 1'b0, up[0]};
                #1;
                check("R7 quad4 isolation", comb_lo, exp_lo);
            end
        end
    endtask

    task automatic t_pair5();
        mask = 64'hF0E1_D2C3_B4A5_9687;
        set_cfg(0, 0, 0, 0, 1);
        sweep("R3 pair5", 0);
    endtask

    task automatic t_wide6();
        mask = 64'h8E3B_1F60_A7C4_52D9;
        set_cfg(1, 0, 0, 0, 0);
        sweep("R4 wide6", 1);
        set_cfg(1, 1, 1, 1, 1);    // R1: no earlier mode matches, tie wins
        sweep("R4 wide6 priority R1", 1);
    endtask

    task automatic t_twin6();
        mask = 64'h36C9_A55A_0FF0_C3C3;
        set_cfg(0, 1, 1, 0, 1);
        sweep("R5 twin6", 0);
        set_cfg(1, 1, 1, 0, 1);    // R1: twin beats tie
        sweep("R5 twin6 over tie R1", 0);
    endtask

    task automatic t_part7();
        mask = 64'hD1B7_4E28_93FA_6C05;
        set_cfg(0, 0, 1, 1, 0);
        sweep("R6 part7", 0);
        set_cfg(1, 0, 1, 1, 1);    // R1: part7 beats tie and spread
        sweep("R6 part7 priority R1", 0);
        // R6: the lower stage select has no effect
        for (int v = 0; v < 128; v++) begin
            logic a, b;
            lut_in = 8'(v);
            #1; a = comb_hi;
            lut_in = 8'(v) | 8'h80;
            #1; b = comb_hi;
            check("R6 part7 SL ignored", b, a);
        end
    endtask

    task automatic t_registers();
        logic [7:0] vecs [4] = '{8'h13, 8'hC6, 8'h7B, 8'hA0};
        bit eh, el;
        mask = 64'hF0E1_D2C3_B4A5_9687;
        set_cfg(0, 0, 0, 0, 1);
        // R8: capture on enable
        foreach (vecs[k]) begin
            @(negedge clk);
            ff_en = 1; ff_clr = 0; lut_in = vecs[k];
            eh = ref_out(1, mask, vecs[k], 1'b1);
            el = ref_out(1, mask, vecs[k], 1'b0);
            @(negedge clk);
            check("R8 capture hi", reg_hi, eh);
            check("R8 capture lo", reg_lo, el);
        end
        // find a vector that gives ones so hold and clear are visible
        @(negedge clk);
        lut_in = 8'h00;
        for (int v = 0; v < 256; v++) begin
            if (ref_out(1, mask, 8'(v), 1'b1) && ref_out(1, mask, 8'(v), 1'b0)) lut_in = 8'(v);
        end
        @(negedge clk);
        check("R8 load ones hi", reg_hi, 1'b1);
        check("R8 load ones lo", reg_lo, 1'b1);
        // R9: hold while enable is low and inputs change
        ff_en = 0;
        for (int v = 0; v < 8; v++) begin
            lut_in = 8'(v * 37);
            @(negedge clk);
            check("R9 hold hi", reg_hi, 1'b1);
            check("R9 hold lo", reg_lo, 1'b1);
        end
        // R10: clear wins over enable
        ff_en = 1; ff_clr = 1;
        @(negedge clk);
        check("R10 clear hi", reg_hi, 1'b0);
        check("R10 clear lo", reg_lo, 1'b0);
        ff_clr = 0;
        @(negedge clk);
        check("R8 reload hi", reg_hi, ref_out(1, mask, lut_in, 1'b1));
        // R10: reset also clears
        rst = 1;
        @(negedge clk);
        check("R10 rst hi", reg_hi, 1'b0);
        check("R10 rst lo", reg_lo, 1'b0);
        rst = 0; ff_en = 0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset_state();
        t_quad4();
        t_isolation();
        t_pair5();
        t_wide6();
        t_twin6();
        t_part7();
        t_registers();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule